// File: doc/BRIEF.md
# Word-Aligned Instruction Fetch Unit

This block holds the program counter of a single-cycle processor and picks the next instruction address on every rising clock edge. The counter keeps only the word part of the address (the upper 30 bits of a 32-bit byte address). The byte address sent to the instruction memory is that word index with two zero bits appended. Because of this, a sequential step adds one to the counter, and a branch offset is added as a word count with no shift logic.

Each cycle the instruction word returned by memory is passed straight on to the decoder. Its low 16 bits are used as a signed branch offset, and its low 26 bits are used as a jump target. A small selector chooses among four next-address sources. It evaluates them in fixed priority: `NXT_RESET` (synchronous reset loads the reset vector), then `NXT_JUMP` (the upper four counter bits are kept and the 26-bit target field replaces the rest), then `NXT_BRANCH` (branch select and the equality flag are both high, so the next value is counter + 1 + sign-extended offset), and finally `NXT_SEQ` (counter + 1). The counter + 1 sum and the branch-target sum are both computed every cycle, and a multiplexer picks one of them. The selection is the block's only state transition, and the counter register is its only state.

Top module: `word_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads `RESET_VEC` (default 0) on that edge, so `imem_addr` reads `RESET_VEC` after it.
- R2: Bits 1:0 of `imem_addr` are always 0. Bits 31:2 are the stored word counter.
- R3: With `rst`, `jump_sel` low and no taken branch, `imem_addr` increases by 4 at each edge, wrapping modulo 2^32.
- R4: With `br_sel` = 1 and `eq_flag` = 1 (and no jump or reset), the next word counter is counter + 1 + sign-extended `imem_data[15:0]`. This includes the largest positive offset, 0x7FFF.
- R5: `br_sel` = 1 with `eq_flag` = 0 gives a sequential step. `eq_flag` = 1 with `br_sel` = 0 also gives a sequential step.
- R6: A branch offset with bit 15 set moves the counter backward, and it wraps below zero to the top of the address space.
- R7: With `jump_sel` = 1, the next word counter is {current `imem_addr[31:28]`, `imem_data[25:0]`}. Bits 31:26 of the instruction word have no effect.
- R8: `jump_sel` takes priority over a taken branch.
- R9: `rst` takes priority over both jump and branch.
- R10: `instr_out` equals `imem_data` within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_data | input | 32 | Instruction word returned by the instruction memory |
| br_sel | input | 1 | Branch-select control from the decoder |
| eq_flag | input | 1 | Register equality flag from the datapath |
| jump_sel | input | 1 | Jump control from the decoder |
| imem_addr | output | 32 | Byte address to the instruction memory, word aligned |
| instr_out | output | 32 | Instruction word passed to decode |

## Verification
The hardest case to reach from the ports is a counter whose upper four bits are all ones. A jump can never set those bits, and the sequential path would take billions of cycles to get there. The stimulus gets there quickly: from address zero, a taken branch with offset -2 wraps the counter to all ones. A sequential step then checks the wrap back to zero. The same backward branch is applied again, and a following jump checks that the high nibble 1111 is kept while the target bits and the ignored bits 31:26 of the instruction are applied.

// File: rtl/wfu_pkg.sv
package wfu_pkg;
    // next-address source, listed from lowest to highest priority
    typedef enum logic [1:0] {
        NXT_SEQ    = 2'd0,
        NXT_BRANCH = 2'd1,
        NXT_JUMP   = 2'd2,
        NXT_RESET  = 2'd3
    } nxt_sel_e;
endpackage

// File: rtl/wfu_select.sv
module wfu_select
    import wfu_pkg::*;
(
    input  logic     rst,
    input  logic     jump_sel,
    input  logic     br_sel,
    input  logic     eq_flag,
    output nxt_sel_e sel
);
    // fixed priority: reset, jump, taken branch, sequential
    always_comb begin
        if (rst)
            sel = NXT_RESET;
        else if (jump_sel)
            sel = NXT_JUMP;
        else if (br_sel && eq_flag)
            sel = NXT_BRANCH;
        else
            sel = NXT_SEQ;
    end
endmodule

// File: rtl/wfu_next_addr.sv
module wfu_next_addr
    import wfu_pkg::*;
#(
    parameter int PC_W  = 30,
    parameter int IMM_W = 16,
    parameter int TGT_W = 26,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TGT_W-1:0] field,
    input  nxt_sel_e         sel,
    output logic [PC_W-1:0]  next_pc
);
    localparam int HI_W  = PC_W - TGT_W;
    localparam int EXT_W = PC_W - IMM_W;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] br_pc;
    logic [PC_W-1:0] jmp_pc;
    logic [PC_W-1:0] offset;

    // word offset, sign-extended; no shift needed on a word counter
    assign offset = {{EXT_W{field[IMM_W-1]}}, field[IMM_W-1:0]};

    // both adders run every cycle
    assign seq_pc = pc + PC_W'(1);
    assign br_pc  = seq_pc + offset;

    generate
        if (HI_W > 0) begin : g_region
            assign jmp_pc = {pc[PC_W-1 -: HI_W], field};
        end else begin : g_flat
            assign jmp_pc = field[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            NXT_RESET:  next_pc = RESET_PC;
            NXT_JUMP:   next_pc = jmp_pc;
            NXT_BRANCH: next_pc = br_pc;
            default:    next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/wfu_pc_reg.sv
module wfu_pc_reg #(
    parameter int PC_W = 30
) (
    input  logic            clk,
    input  logic [PC_W-1:0] next_pc,
    output logic [PC_W-1:0] pc
);
    // reset value arrives through next_pc, so one edge-triggered load suffices
    always_ff @(posedge clk) begin
        pc <= next_pc;
    end
endmodule

// File: rtl/word_fetch_unit.sv
module word_fetch_unit
    import wfu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INSTR_W = 32,
    parameter int IMM_W = 16,
    parameter int TGT_W = 26,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] imem_data,
    input  logic               br_sel,
    input  logic               eq_flag,
    input  logic               jump_sel,
    output logic [ADDR_W-1:0]  imem_addr,
    output logic [INSTR_W-1:0] instr_out
);
    localparam int PC_W = ADDR_W - 2;
    localparam logic [PC_W-1:0] RESET_PC = RESET_VEC[ADDR_W-1:2];

    nxt_sel_e        sel;
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] next_pc;

    wfu_select u_select (
        .rst      (rst),
        .jump_sel (jump_sel),
        .br_sel   (br_sel),
        .eq_flag  (eq_flag),
        .sel      (sel)
    );

    wfu_next_addr #(
        .PC_W     (PC_W),
        .IMM_W    (IMM_W),
        .TGT_W    (TGT_W),
        .RESET_PC (RESET_PC)
    ) u_next (
        .pc      (pc),
        .field   (imem_data[TGT_W-1:0]),
        .sel     (sel),
        .next_pc (next_pc)
    );

    wfu_pc_reg #(
        .PC_W (PC_W)
    ) u_pc (
        .clk     (clk),
        .next_pc (next_pc),
        .pc      (pc)
    );

    assign imem_addr = {pc, 2'b00};
    assign instr_out = imem_data;
endmodule

// File: rtl/wfu_checker.sv
module wfu_checker #(
    parameter int ADDR_W = 32,
    parameter int IMM_W = 16,
    parameter int TGT_W = 26,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              br_sel,
    input logic              eq_flag,
    input logic              jump_sel,
    input logic [TGT_W-1:0]  field,
    input logic [ADDR_W-1:0] imem_addr
);
    localparam int PC_W = ADDR_W - 2;
    localparam int HI_W = PC_W - TGT_W;

    logic seen_q = 1'b0;
    logic live_q = 1'b0;
    logic [PC_W-1:0] offs;

    always_ff @(posedge clk) begin
        seen_q <= 1'b1;
        live_q <= !rst;
    end

    assign offs = {{(PC_W-IMM_W){field[IMM_W-1]}}, field[IMM_W-1:0]};

    p_reset_vec_r1: assert property (@(posedge clk) disable iff (!seen_q)
        $past(rst) |-> imem_addr == RESET_VEC);

    p_aligned_r2: assert property (@(posedge clk) disable iff (rst || !live_q)
        imem_addr[1:0] == 2'b00);

    p_seq_step_r3: assert property (@(posedge clk) disable iff (rst || !live_q)
        (!$past(jump_sel) && !($past(br_sel) && $past(eq_flag)))
            |-> imem_addr == $past(imem_addr) + ADDR_W'(4));

    p_branch_r4: assert property (@(posedge clk) disable iff (rst || !live_q)
        (!$past(jump_sel) && $past(br_sel) && $past(eq_flag))
            |-> imem_addr[ADDR_W-1:2] == $past(imem_addr[ADDR_W-1:2]) + PC_W'(1) + $past(offs));

    p_jump_r7: assert property (@(posedge clk) disable iff (rst || !live_q)
        $past(jump_sel)
            |-> imem_addr[ADDR_W-1:2] == {$past(imem_addr[ADDR_W-1 -: HI_W]), $past(field)});
endmodule

bind word_fetch_unit wfu_checker #(
    .ADDR_W    (ADDR_W),
    .IMM_W     (IMM_W),
    .TGT_W     (TGT_W),
    .RESET_VEC (RESET_VEC)
) u_wfu_checker (
    .clk       (clk),
    .rst       (rst),
    .br_sel    (br_sel),
    .eq_flag   (eq_flag),
    .jump_sel  (jump_sel),
    .field     (imem_data[TGT_W-1:0]),
    .imem_addr (imem_addr)
);

// File: tb/word_fetch_unit_test.sv
module word_fetch_unit_test;
    localparam int PERIOD = 10;
    localparam int NVEC = 16;

    typedef struct packed {
        logic        rst;
        logic        jmp;
        logic        br;
        logic        eq;
        logic [31:0] data;
        logic [31:0] exp;
        logic [23:0] tag;
    } vec_t;

    // each row: controls and instruction word for one cycle, byte address expected after the edge
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, "R1 "},
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h0000_0004, "R3 "},
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h0000_0008, "R3 "},
        '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0010, 32'h0000_000C, "R5 "},
        '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0010, 32'h0000_0010, "R5 "},
        '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0003, 32'h0000_0020, "R4 "},
        '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_FFFE, 32'h0000_001C, "R6 "},
        '{1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0100, 32'h0000_0400, "R7 "},
        '{1'b0, 1'b1, 1'b1, 1'b1, 32'h03FF_FFF0, 32'h0FFF_FFC0, "R8 "},
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0FFF_FFC4, "R3 "},
        '{1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0100, 32'h0000_0000, "R9 "},
        '{1'b0, 1'b0, 1'b1, 1'b1, 32'h1000_FFFE, 32'hFFFF_FFFC, "R6 "},
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, "R3 "},
        '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_FFFE, 32'hFFFF_FFFC, "R6 "},
        '{1'b0, 1'b1, 1'b0, 1'b0, 32'h0800_0005, 32'hF000_0014, "R7 "},
        '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_7FFF, 32'hF002_0014, "R4 "}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_data = '0;
    logic        br_sel = 1'b0;
    logic        eq_flag = 1'b0;
    logic        jump_sel = 1'b0;
    logic [31:0] imem_addr;
    logic [31:0] instr_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    word_fetch_unit uut (
        .clk       (clk),
        .rst       (rst),
        .imem_data (imem_data),
        .br_sel    (br_sel),
        .eq_flag   (eq_flag),
        .jump_sel  (jump_sel),
        .imem_addr (imem_addr),
        .instr_out (instr_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        @(posedge clk);
        #1;
        for (int i = 0; i < NVEC; i++) begin
            rst       = VECS[i].rst;
            jump_sel  = VECS[i].jmp;
            br_sel    = VECS[i].br;
            eq_flag   = VECS[i].eq;
            imem_data = VECS[i].data;
            #1;
            chk("R10 passthrough", instr_out, VECS[i].data);
            @(posedge clk);
            #1;
            chk(string'(VECS[i].tag), imem_addr, VECS[i].exp);
            chk("R2 alignment", {30'd0, imem_addr[1:0]}, 32'd0);
        end

        // R1: reset held over two edges keeps the reset vector
        rst = 1'b1; jump_sel = 1'b0; br_sel = 1'b0; eq_flag = 1'b0;
        @(posedge clk); #1;
        chk("R1 reset first edge", imem_addr, 32'h0);
        @(posedge clk); #1;
        chk("R1 reset second edge", imem_addr, 32'h0);

        // R10: instruction word follows memory data mid-cycle with no edge
        rst = 1'b0;
        imem_data = 32'hA5A5_0F0F;
        #1;
        chk("R10 mid-cycle A", instr_out, 32'hA5A5_0F0F);
        imem_data = 32'h5A5A_F0F0;
        #1;
        chk("R10 mid-cycle B", instr_out, 32'h5A5A_F0F0);
        chk("R10 no edge keeps address", imem_addr, 32'h0);

        // R5: eq without br_sel steps sequentially from zero
        br_sel = 1'b0; eq_flag = 1'b1; imem_data = 32'h0000_0100;
        @(posedge clk); #1;
        chk("R5 eq only", imem_addr, 32'h4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 2000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule